// File: doc/BRIEF.md
# Lock-on-Fill Cache Tag Controller

This block holds the tags and per-block state of a set-associative cache in which every block fetched on a miss is pinned: it cannot be replaced until the external address-permutation engine finishes a pass. Each memory block is therefore read from memory at most once between permutations, so the order of fetches on the memory bus tells an observer nothing about repeated use. Hits of either kind take the ordinary path and leave the pin state alone.

The controller picks a victim only among unpinned ways, using a round-robin pointer for each set. It reports a dirty victim on the evict port before it asks for the fill. When half of all blocks are pinned it raises an early, level-held permutation request. When a miss lands in a set whose ways are all pinned, it stalls the request and holds a mandatory permutation request until the engine signals completion. Completion unpins every block. The data array and the permutation engine are outside this block.

Address layout: offset `[OFF_W-1:0]`, set index in the next `log2(SETS)` bits, tag in the rest. With the defaults (16-bit address, 4-bit offset, 16 sets, 4 ways) the set index is bits `[7:4]` and the tag is bits `[15:8]`.

Top module: `lof_cache_ctrl`

## Requirements
- R1: When idle, a valid request whose tag matches a valid way of its set completes in the same cycle with `req_ready_o`=1 and `resp_hit_o`=1. No fill, evict or permutation request is raised and no pin bit changes. A write hit marks the block dirty.
- R2: A miss with an unpinned way in its set raises `fill_req_o` with `fill_addr_o` equal to the request address with its offset bits cleared. The cycle in which `fill_done_i` is high completes the request with `req_ready_o`=1 and `resp_hit_o`=0, and installs the block valid and pinned. A later access to the same block hits.
- R3: The victim is the first unpinned way found from the set's round-robin pointer upward (modulo WAYS). After a fill the pointer moves to the way just past the filled one. A pinned way is never a victim.
- R4: A miss to a set whose ways are all pinned raises `perm_req_o` and keeps it high, with no fill and no completion, until `perm_done_i` is seen. That completion unpins every block in every set. The stalled request then proceeds as an ordinary miss.
- R5: `perm_early_o` rises one cycle after the pinned-block count reaches SETS*WAYS/2. It stays low at one block fewer. Once high it stays high until `perm_done_i`, and then falls.
- R6: `perm_done_i` is ignored, and leaves all pin bits unchanged, when neither `perm_early_o` nor `perm_req_o` is high.
- R7: If the chosen victim is valid and dirty, `evict_valid_o` is raised first, with `evict_addr_o` = {victim tag, set index, zero offset}, and is held until `evict_ready_i`. Only then is `fill_req_o` raised. A clean victim produces no evict.
- R8: After reset every block is invalid, clean and unpinned, and all handshake outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request valid, held until `req_ready_o` |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | Request byte address |
| req_ready_o | output | 1 | Request completes this cycle |
| resp_hit_o | output | 1 | Completed request was a hit |
| evict_valid_o | output | 1 | Dirty victim write-back request |
| evict_addr_o | output | ADDR_W | Block address of the victim |
| evict_ready_i | input | 1 | Write-back accepted |
| fill_req_o | output | 1 | Block fetch request |
| fill_addr_o | output | ADDR_W | Block address to fetch |
| fill_done_i | input | 1 | Fetched block delivered |
| perm_early_o | output | 1 | Early permutation request (half pinned) |
| perm_req_o | output | 1 | Mandatory permutation request (stall) |
| perm_done_i | input | 1 | Permutation finished, unpin all |

## Verification
The bench builds the block with its defaults: 4 ways, 16 sets and a 16-bit address. A set therefore fills up after four misses, which brings the stall, the wrap of the round-robin pointer and the dirty eviction after a permutation within a few accesses. The 32-block early threshold takes only 32 misses spread over all sets, so the 31/32 boundary, the held level and the global unpin are all tested directly at the ports.

// File: rtl/lof_pkg.sv
package lof_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_PERM  = 2'd3
  } lof_state_e;
endpackage

// File: rtl/lof_tag_match.sv
module lof_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/lof_victim.sv
module lof_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  lock_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic             free_o,
  output logic [WAY_W-1:0] victim_o
);
  always_comb begin
    logic [WAY_W-1:0] cand;
    free_o   = 1'b0;
    victim_o = ptr_i;
    for (int k = 0; k < WAYS; k++) begin
      cand = ptr_i + WAY_W'(k);
      if (!free_o && !lock_i[cand]) begin
        free_o   = 1'b1;
        victim_o = cand;
      end
    end
  end

  // R3: a pinned way is never offered
  always_comb begin
    if (free_o) begin
      a_r3_victim_unlocked: assert (!lock_i[victim_o])
        else $error("pinned way chosen as victim");
    end
  end
endmodule

// File: rtl/lof_lock_track.sv
module lof_lock_track #(
  parameter int BLOCKS = 64,
  localparam int CNT_W = $clog2(BLOCKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLOCKS-1:0] lock_i,
  input  logic              clear_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              early_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(BLOCKS / 2);

  always_comb begin
    cnt_o = '0;
    for (int b = 0; b < BLOCKS; b++) cnt_o = cnt_o + CNT_W'(lock_i[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             early_o <= 1'b0;
    else if (clear_i)        early_o <= 1'b0;
    else if (cnt_o >= HALF)  early_o <= 1'b1;
  end

  a_r5_early_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o && !clear_i |=> early_o);
endmodule

// File: rtl/lof_cache_ctrl.sv
module lof_cache_ctrl
  import lof_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_hit_o,
  output logic              evict_valid_o,
  output logic [ADDR_W-1:0] evict_addr_o,
  input  logic              evict_ready_i,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_done_i,
  output logic              perm_early_o,
  output logic              perm_req_o,
  input  logic              perm_done_i
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLOCKS = SETS * WAYS;
  localparam int CNT_W  = $clog2(BLOCKS + 1);

  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0]            lock_q [SETS];
  logic [WAY_W-1:0]           ptr_q [SETS];

  lof_state_e       state_q, state_d;
  logic [TAG_W-1:0] m_tag_q;
  logic [IDX_W-1:0] m_idx_q;
  logic [WAY_W-1:0] vway_q;
  logic             m_wr_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit, free;
  logic [WAY_W-1:0] hit_way, victim;
  logic [BLOCKS-1:0] lock_flat;
  logic [CNT_W-1:0] lock_cnt;
  logic             perm_ack, hit_done, fill_done, miss_go;
  logic             unused_offset;

  assign idx = req_addr_i[OFF_W +: IDX_W];
  assign tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^req_addr_i[OFF_W-1:0];

  lof_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i (tag_q[idx]),
    .valid_i(valid_q[idx]),
    .tag_i  (tag),
    .hit_o  (hit),
    .way_o  (hit_way)
  );

  lof_victim #(.WAYS(WAYS)) u_victim (
    .lock_i  (lock_q[idx]),
    .ptr_i   (ptr_q[idx]),
    .free_o  (free),
    .victim_o(victim)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_flat
    assign lock_flat[s*WAYS +: WAYS] = lock_q[s];
  end

  lof_lock_track #(.BLOCKS(BLOCKS)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (lock_flat),
    .clear_i(perm_ack),
    .cnt_o  (lock_cnt),
    .early_o(perm_early_o)
  );

  // Done only counts while a permutation was asked for
  assign perm_ack  = perm_done_i && (perm_early_o || state_q == ST_PERM);
  assign hit_done  = state_q == ST_IDLE && req_valid_i && hit;
  assign miss_go   = state_q == ST_IDLE && req_valid_i && !hit && free;
  assign fill_done = state_q == ST_FILL && fill_done_i;

  always_comb begin
    state_d       = state_q;
    req_ready_o   = 1'b0;
    resp_hit_o    = 1'b0;
    evict_valid_o = 1'b0;
    fill_req_o    = 1'b0;
    perm_req_o    = 1'b0;
    evict_addr_o  = {tag_q[m_idx_q][vway_q], m_idx_q, {OFF_W{1'b0}}};
    fill_addr_o   = {m_tag_q, m_idx_q, {OFF_W{1'b0}}};
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (hit) begin
            req_ready_o = 1'b1;
            resp_hit_o  = 1'b1;
          end else if (!free) begin
            state_d = ST_PERM;
          end else if (valid_q[idx][victim] && dirty_q[idx][victim]) begin
            state_d = ST_EVICT;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        evict_valid_o = 1'b1;
        if (evict_ready_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        fill_req_o = 1'b1;
        if (fill_done_i) begin
          req_ready_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      ST_PERM: begin
        perm_req_o = 1'b1;
        if (perm_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      m_tag_q <= '0;
      m_idx_q <= '0;
      vway_q  <= '0;
      m_wr_q  <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]   <= '0;
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        lock_q[s]  <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      state_q <= state_d;
      if (miss_go) begin
        m_tag_q <= tag;
        m_idx_q <= idx;
        vway_q  <= victim;
        m_wr_q  <= req_write_i;
      end
      if (hit_done && req_write_i) dirty_q[idx][hit_way] <= 1'b1;
      if (perm_ack) begin
        for (int s = 0; s < SETS; s++) lock_q[s] <= '0;
      end
      // fill pin wins over a same-cycle unpin
      if (fill_done) begin
        tag_q[m_idx_q][vway_q]   <= m_tag_q;
        valid_q[m_idx_q][vway_q] <= 1'b1;
        dirty_q[m_idx_q][vway_q] <= m_wr_q;
        lock_q[m_idx_q][vway_q]  <= 1'b1;
        ptr_q[m_idx_q]           <= vway_q + WAY_W'(1);
      end
    end
  end

  a_r1_hit_keeps_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_done && !perm_ack |=> $stable(lock_cnt));
  a_r2_fill_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_done_i |=> fill_req_o && $stable(fill_addr_o));
  a_r4_perm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_req_o && !perm_done_i |=> perm_req_o && !req_ready_o);
  a_r4_perm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_req_o && perm_done_i |=> lock_cnt == '0);
  a_r7_evict_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o && !evict_ready_i |=> evict_valid_o && $stable(evict_addr_o));
  a_r7_evict_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o && evict_ready_i |=> fill_req_o);
endmodule

// File: tb/sim_lof_cache_ctrl.sv
module sim_lof_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, resp_hit;
  logic        evict_valid, evict_ready = 1'b0;
  logic [15:0] evict_addr;
  logic        fill_req, fill_done = 1'b0;
  logic [15:0] fill_addr;
  logic        perm_early, perm_req, perm_done = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lof_cache_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .resp_hit_o(resp_hit),
    .evict_valid_o(evict_valid), .evict_addr_o(evict_addr), .evict_ready_i(evict_ready),
    .fill_req_o(fill_req), .fill_addr_o(fill_addr), .fill_done_i(fill_done),
    .perm_early_o(perm_early), .perm_req_o(perm_req), .perm_done_i(perm_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 0; evict_ready = 0; fill_done = 0; perm_done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // acts as memory and permutation engine; pdelay = cycles perm_req held before done
  task automatic access(input logic [15:0] a, input logic wr, input int pdelay,
                        output logic hit, output logic ev, output logic [15:0] eva,
                        output logic pm, output int bad);
    int pcnt = 0;
    bit done = 0;
    hit = 0; ev = 0; eva = '0; pm = 0; bad = 0;
    for (int cyc = 0; cyc < 60 && !done; cyc++) begin
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a;
      if (evict_valid) begin
        ev = 1; eva = evict_addr; evict_ready = 1;
        if (fill_req) bad++;
      end
      if (fill_req) begin
        if (fill_addr != (a & 16'hFFF0)) bad++;
        fill_done = 1;
      end
      if (perm_req) begin
        pm = 1;
        if (fill_req) bad++;
        if (pcnt >= pdelay) perm_done = 1;
        pcnt++;
      end
      #1;
      if (perm_req && req_ready) bad++;
      if (req_ready) begin
        done = 1; hit = resp_hit;
      end
      @(posedge clk); #1;
      evict_ready = 0; fill_done = 0; perm_done = 0;
    end
    req_valid = 0;
    if (!done) bad += 100;
  endtask

  function automatic logic [15:0] mk(input logic [7:0] t, input logic [3:0] s, input logic [3:0] o);
    return {t, s, o};
  endfunction

  task automatic t_reset();
    do_reset();
    #1;
    chk(!perm_req && !perm_early, "R8 perm outputs", {perm_req, perm_early}, 0);
    chk(!fill_req && !evict_valid, "R8 fill/evict", {fill_req, evict_valid}, 0);
    chk(!req_ready, "R8 ready", req_ready, 0);
  endtask

  task automatic t_miss_hit();
    logic h, e, p; logic [15:0] ea; int b;
    do_reset();
    access(mk(8'h12, 4'h3, 4'h0), 0, 0, h, e, ea, p, b);
    chk(!h && !e && !p && b == 0, "R2 miss fill", {h, e, p, b[3:0]}, 0);
    access(mk(8'h12, 4'h3, 4'h5), 0, 0, h, e, ea, p, b);
    chk(h && b == 0, "R2 refetch hits", h, 1);
    access(mk(8'h12, 4'h3, 4'h8), 1, 0, h, e, ea, p, b);
    chk(h && !e && !p && b == 0, "R1 write hit", {h, e, p}, 3'b100);
  endtask

  task automatic t_full_set();
    logic h, e, p; logic [15:0] ea; int b;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      access(mk(8'h10 + 8'(i), 4'h2, 4'h0), (i == 0), 0, h, e, ea, p, b);
      chk(!h && !p && b == 0, "R2 fill set 2", {h, p}, 0);
    end
    for (int i = 0; i < 3; i++) access(mk(8'h30 + 8'(i), 4'h5, 4'h0), 0, 0, h, e, ea, p, b);
    for (int i = 0; i < 4; i++) begin
      access(mk(8'h10 + 8'(i), 4'h2, 4'h4), 0, 0, h, e, ea, p, b);
      chk(h && !p, "R1 hit pinned block", {h, p}, 2'b10);
    end
    // R6: stray done while nothing is pending
    @(negedge clk); perm_done = 1; @(negedge clk); perm_done = 0;
    access(mk(8'h14, 4'h2, 4'h0), 0, 3, h, e, ea, p, b);
    chk(p, "R6 stray done ignored, R4 perm raised", p, 1);
    chk(b == 0, "R4 stall no fill while perm", b, 0);
    chk(e && ea == mk(8'h10, 4'h2, 4'h0), "R7 dirty victim evicted", ea, mk(8'h10, 4'h2, 4'h0));
    chk(!h, "R4 resumes as miss", h, 0);
    access(mk(8'h11, 4'h2, 4'h0), 0, 0, h, e, ea, p, b);
    chk(h, "R3 way1 kept", h, 1);
    access(mk(8'h10, 4'h2, 4'h0), 0, 0, h, e, ea, p, b);
    chk(!h && !e && !p, "R3 rr victim way1 clean, R7 no evict", {h, e, p}, 0);
    access(mk(8'h11, 4'h2, 4'h0), 0, 0, h, e, ea, p, b);
    chk(!h, "R3 pointer advanced past way1", h, 0);
    // set 5 pins were cleared too: two more fills without permutation
    access(mk(8'h33, 4'h5, 4'h0), 0, 0, h, e, ea, p, b);
    access(mk(8'h34, 4'h5, 4'h0), 0, 0, h, e, ea, p, b);
    chk(!p && b == 0, "R4 all sets unpinned", p, 0);
  endtask

  task automatic t_early();
    logic h, e, p; logic [15:0] ea; int b;
    do_reset();
    for (int i = 0; i < 31; i++)
      access(mk(8'h20 + 8'(i / 16), 4'(i % 16), 4'h0), 0, 0, h, e, ea, p, b);
    idle(2);
    chk(!perm_early, "R5 low at half minus one", perm_early, 0);
    access(mk(8'h21, 4'hF, 4'h0), 0, 0, h, e, ea, p, b);
    idle(2);
    chk(perm_early, "R5 high at half", perm_early, 1);
    access(mk(8'h22, 4'h0, 4'h0), 0, 0, h, e, ea, p, b);
    idle(1);
    chk(perm_early, "R5 level held", perm_early, 1);
    @(negedge clk); perm_done = 1; @(negedge clk); perm_done = 0;
    chk(!perm_early, "R5 drops after done", perm_early, 0);
    access(mk(8'h23, 4'h0, 4'h0), 0, 0, h, e, ea, p, b);
    access(mk(8'h24, 4'h0, 4'h0), 0, 0, h, e, ea, p, b);
    chk(!p && !h && b == 0, "R4 early done unpinned all", {p, h}, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_miss_hit();
    t_full_set();
    t_early();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule